// File: doc/BRIEF.md
# Early-Prompt-Late Code Correlator

This block despreads a stream of signed in-phase baseband samples against three copies of a binary spreading code. The copies are a leading (early) replica, a centred (prompt) replica and a trailing (late) replica. Each valid sample is multiplied by the current chip of each replica. Because a chip is always +1 or -1, the multiply reduces to passing the sample through or negating it. The three results are summed in separate signed accumulators over one coherent integration period, normally one whole code period.

The integration period ends with a dump strobe. On that strobe the block captures the three sums and the number of samples that went into them. It also computes a coherent discriminator, the signed early sum minus the late sum, and presents all of these with a valid flag. The sample count is reported because a chip covers either the floor of the samples-per-chip ratio or one sample more. The number of correlated samples therefore varies from period to period.

Only one code source is needed. The caller drives the early chip and pulses a strobe at every half-chip boundary. The prompt and late chips come from a two-stage delay line clocked by that strobe, so early and late sit one full chip apart with prompt centred between them.

Top module: `epl_correlator`

## Requirements
- R1: While reset is high, and in the cycle after it, out_valid is 0 and out_early, out_prompt, out_late, out_count and out_disc are all zero.
- R2: A chip value of 0 means +1 and adds the sample to its tap's sum. A chip value of 1 means -1 and subtracts the sample.
- R3: The early tap uses code_chip as driven in the current cycle. The prompt tap uses the code_chip value captured at the most recent half_tick. The late tap uses the value the prompt tap held before that half_tick.
- R4: A sample with smp_valid low changes no sum and no count, whatever smp_data holds. Each sample with smp_valid high raises the count by exactly one.
- R5: One cycle after a dump, out_valid is 1 for exactly one cycle. In that cycle the outputs hold the sums and the count of all valid samples since the previous dump, or since reset.
- R6: A valid sample that arrives in the same cycle as a dump belongs to the new period. It is not included in the values latched by that dump.
- R7: out_disc equals out_early minus out_late, computed at a width one bit wider than the accumulators so that it cannot wrap.
- R8: Between dumps, all latched outputs hold their values.
- R9: A period of 16368 samples (1023 chips at 16 samples per chip) at the most negative sample value -8 accumulates without overflow.
- R10: Dumps in consecutive cycles are allowed. The second dump reports only the sample, if any, that arrived with the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | SMP_W (4) | Signed in-phase sample |
| code_chip | input | 1 | Early replica chip, 0 = +1, 1 = -1 |
| half_tick | input | 1 | Half-chip boundary; shifts the delay line |
| dump | input | 1 | End of integration period |
| out_valid | output | 1 | One-cycle result strobe |
| out_early | output | ACC_W (24) | Signed early correlation |
| out_prompt | output | ACC_W (24) | Signed prompt correlation |
| out_late | output | ACC_W (24) | Signed late correlation |
| out_count | output | CNT_W (16) | Valid samples in the period |
| out_disc | output | ACC_W+1 (25) | Signed early minus late |

## Verification
The dump and an incoming valid sample can fall in the same cycle. When that happens, the old sums must be latched untouched while the accumulators restart from that one sample. The bench provokes this by asserting dump together with a valid sample after a full period. It then checks that the reported values leave that sample out. A second dump in the very next cycle must report a count of one and sums of exactly that sample, signed by each tap's chip.

// File: rtl/epl_pkg.sv
package epl_pkg;

    localparam int SMP_W_DEF = 4;
    localparam int ACC_W_DEF = 24;
    localparam int CNT_W_DEF = 16;

    // tap indices, in order of code lag
    typedef enum int {
        TAP_EARLY  = 0,
        TAP_PROMPT = 1,
        TAP_LATE   = 2
    } tap_e;

    localparam int NUM_TAPS = 3;

    // chip values of the three replicas, 0 = +1, 1 = -1
    typedef struct packed {
        logic early;
        logic prompt;
        logic late;
    } taps_t;

    function automatic logic tap_chip(taps_t t, int idx);
        case (idx)
            TAP_EARLY:  return t.early;
            TAP_PROMPT: return t.prompt;
            default:    return t.late;
        endcase
    endfunction

endpackage

// File: rtl/epl_code_taps.sv
module epl_code_taps
    import epl_pkg::*;
#(
    parameter int DELAY_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  code_chip,
    input  logic  half_tick,
    output taps_t taps_o
);

    logic [DELAY_STAGES-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q[0] <= 1'b0;
        end else if (half_tick) begin
            sh_q[0] <= code_chip;
        end
    end

    for (genvar i = 1; i < DELAY_STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                sh_q[i] <= 1'b0;
            end else if (half_tick) begin
                sh_q[i] <= sh_q[i-1];
            end
        end
    end

    always_comb begin
        taps_o.early  = code_chip;
        taps_o.prompt = sh_q[0];
        taps_o.late   = sh_q[DELAY_STAGES-1];
    end

    // R3: prompt takes the early chip seen at the boundary
    a_r3_prompt_follows: assert property (@(posedge clk) disable iff (rst)
        half_tick |=> taps_o.prompt == $past(taps_o.early));

    // R3: late takes the prompt chip seen at the boundary
    a_r3_late_follows: assert property (@(posedge clk) disable iff (rst)
        half_tick |=> taps_o.late == $past(taps_o.prompt));

    // R3: no boundary, prompt and late stand still
    a_r3_taps_still: assert property (@(posedge clk) disable iff (rst)
        !half_tick |=> ($stable(taps_o.prompt) && $stable(taps_o.late)));

endmodule

// File: rtl/epl_tap_accum.sv
module epl_tap_accum #(
    parameter int SMP_W = 4,
    parameter int ACC_W = 24
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    smp_valid,
    input  logic signed [SMP_W-1:0] smp_data,
    input  logic                    chip,
    input  logic                    dump,
    output logic signed [ACC_W-1:0] acc_o
);

    localparam int EXT_W = ACC_W - SMP_W;

    logic signed [ACC_W-1:0] ext;
    logic signed [ACC_W-1:0] prod;
    logic signed [ACC_W-1:0] acc_q;

    always_comb begin
        ext  = {{EXT_W{smp_data[SMP_W-1]}}, smp_data};
        prod = chip ? -ext : ext;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (dump) begin
            acc_q <= smp_valid ? prod : '0;
        end else if (smp_valid) begin
            acc_q <= acc_q + prod;
        end
    end

    assign acc_o = acc_q;

    // R4: invalid samples leave the sum alone
    a_r4_sum_hold: assert property (@(posedge clk) disable iff (rst)
        (!smp_valid && !dump) |=> $stable(acc_q));

    // R6: a dump without a sample starts the new period at zero
    a_r6_sum_restart: assert property (@(posedge clk) disable iff (rst)
        (dump && !smp_valid) |=> acc_q == '0);

    // R2: a single sample in a fresh period has the magnitude of the sample
    a_r2_first_sign: assert property (@(posedge clk) disable iff (rst)
        (dump && smp_valid && !chip) |=> acc_q == $past(ext));

endmodule

// File: rtl/epl_sample_count.sv
module epl_sample_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_valid,
    input  logic             dump,
    output logic [CNT_W-1:0] cnt_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (dump) begin
            cnt_q <= smp_valid ? CNT_W'(1) : '0;
        end else if (smp_valid) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign cnt_o = cnt_q;

    // R6: a sample arriving with the dump opens the new count
    a_r6_count_restart: assert property (@(posedge clk) disable iff (rst)
        (dump && smp_valid) |=> cnt_q == CNT_W'(1));

    // R4: count advances by one per valid sample within a period
    a_r4_count_step: assert property (@(posedge clk) disable iff (rst)
        (!dump && smp_valid) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

endmodule

// File: rtl/epl_dump_latch.sv
module epl_dump_latch #(
    parameter int ACC_W = 24,
    parameter int CNT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    dump,
    input  logic signed [ACC_W-1:0] acc_early,
    input  logic signed [ACC_W-1:0] acc_prompt,
    input  logic signed [ACC_W-1:0] acc_late,
    input  logic [CNT_W-1:0]        cnt,
    output logic                    out_valid,
    output logic signed [ACC_W-1:0] out_early,
    output logic signed [ACC_W-1:0] out_prompt,
    output logic signed [ACC_W-1:0] out_late,
    output logic [CNT_W-1:0]        out_count,
    output logic signed [ACC_W:0]   out_disc
);

    logic signed [ACC_W:0] disc;

    always_comb begin
        disc = {acc_early[ACC_W-1], acc_early} - {acc_late[ACC_W-1], acc_late};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_early  <= '0;
            out_prompt <= '0;
            out_late   <= '0;
            out_count  <= '0;
            out_disc   <= '0;
        end else begin
            out_valid <= dump;
            if (dump) begin
                out_early  <= acc_early;
                out_prompt <= acc_prompt;
                out_late   <= acc_late;
                out_count  <= cnt;
                out_disc   <= disc;
            end
        end
    end

    // R1: reset empties the result registers
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!out_valid && out_count == '0 && out_disc == '0));

    // R5: the strobe lasts one cycle unless another dump follows
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !dump) |=> !out_valid);

    // R8: results stay put while no new result is announced
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> ($stable(out_early) && $stable(out_late) &&
                        $stable(out_prompt) && $stable(out_count)));

    // R7: discriminator matches the latched early and late sums
    a_r7_disc: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_disc == ({out_early[ACC_W-1], out_early} -
                                   {out_late[ACC_W-1], out_late}));

endmodule

// File: rtl/epl_correlator.sv
module epl_correlator
    import epl_pkg::*;
#(
    parameter int SMP_W = SMP_W_DEF,
    parameter int ACC_W = ACC_W_DEF,
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    smp_valid,
    input  logic signed [SMP_W-1:0] smp_data,
    input  logic                    code_chip,
    input  logic                    half_tick,
    input  logic                    dump,
    output logic                    out_valid,
    output logic signed [ACC_W-1:0] out_early,
    output logic signed [ACC_W-1:0] out_prompt,
    output logic signed [ACC_W-1:0] out_late,
    output logic [CNT_W-1:0]        out_count,
    output logic signed [ACC_W:0]   out_disc
);

    localparam int DELAY_STAGES = NUM_TAPS - 1;

    taps_t                   taps;
    logic signed [ACC_W-1:0] acc [NUM_TAPS];
    logic [CNT_W-1:0]        cnt;

    epl_code_taps #(
        .DELAY_STAGES(DELAY_STAGES)
    ) u_taps (
        .clk      (clk),
        .rst      (rst),
        .code_chip(code_chip),
        .half_tick(half_tick),
        .taps_o   (taps)
    );

    for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
        epl_tap_accum #(
            .SMP_W(SMP_W),
            .ACC_W(ACC_W)
        ) u_acc (
            .clk      (clk),
            .rst      (rst),
            .smp_valid(smp_valid),
            .smp_data (smp_data),
            .chip     (tap_chip(taps, t)),
            .dump     (dump),
            .acc_o    (acc[t])
        );
    end

    epl_sample_count #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .smp_valid(smp_valid),
        .dump     (dump),
        .cnt_o    (cnt)
    );

    epl_dump_latch #(
        .ACC_W(ACC_W),
        .CNT_W(CNT_W)
    ) u_latch (
        .clk       (clk),
        .rst       (rst),
        .dump      (dump),
        .acc_early (acc[TAP_EARLY]),
        .acc_prompt(acc[TAP_PROMPT]),
        .acc_late  (acc[TAP_LATE]),
        .cnt       (cnt),
        .out_valid (out_valid),
        .out_early (out_early),
        .out_prompt(out_prompt),
        .out_late  (out_late),
        .out_count (out_count),
        .out_disc  (out_disc)
    );

endmodule

// File: tb/tb_epl_correlator.sv
module tb_epl_correlator;

    logic              clk = 1'b0;
    logic              rst;
    logic              smp_valid;
    logic signed [3:0] smp_data;
    logic              code_chip;
    logic              half_tick;
    logic              dump;
    logic              out_valid;
    logic signed [23:0] out_early, out_prompt, out_late;
    logic [15:0]       out_count;
    logic signed [24:0] out_disc;

    int n_checks = 0;
    int n_err    = 0;

    always #5 clk = ~clk;

    epl_correlator dut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .code_chip(code_chip), .half_tick(half_tick), .dump(dump),
        .out_valid(out_valid), .out_early(out_early), .out_prompt(out_prompt),
        .out_late(out_late), .out_count(out_count), .out_disc(out_disc)
    );

    typedef struct packed {
        logic signed [3:0] s;
        logic [7:0]        n;
        logic              e;
        logic              p;
        logic              l;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{4'sd3,  8'd10, 1'b0, 1'b0, 1'b0},
        '{-4'sd5, 8'd7,  1'b1, 1'b0, 1'b1},
        '{4'sd7,  8'd12, 1'b0, 1'b1, 1'b1},
        '{-4'sd8, 8'd5,  1'b1, 1'b1, 1'b0},
        '{4'sd1,  8'd40, 1'b0, 1'b0, 1'b1},
        '{-4'sd2, 8'd3,  1'b1, 1'b0, 1'b0}
    };

    task automatic check(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic signed [3:0] s,
                        input logic c, input logic t, input logic d);
        smp_valid = v;
        smp_data  = s;
        code_chip = c;
        half_tick = t;
        dump      = d;
        @(negedge clk);
    endtask

    function automatic longint signed_prod(logic chip, longint v);
        return chip ? -v : v;
    endfunction

    // load late, then prompt, then leave early on code_chip
    task automatic set_taps(input logic e, input logic p, input logic l);
        step(1'b0, 4'sd0, l, 1'b1, 1'b0);
        step(1'b0, 4'sd0, p, 1'b1, 1'b0);
        step(1'b0, 4'sd0, e, 1'b0, 1'b0);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        smp_valid = 1'b0; smp_data = 4'sd0; code_chip = 1'b0;
        half_tick = 1'b0; dump = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 valid in reset", longint'(out_valid), 0);
        check("R1 early in reset", longint'(out_early), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid after reset", longint'(out_valid), 0);
        check("R1 count after reset", longint'(out_count), 0);
        check("R1 disc after reset", longint'(out_disc), 0);

        // table of single-period cases
        for (int i = 0; i < NV; i++) begin
            longint ee, pp, ll, base;
            vec_t v;
            v = VECS[i];
            base = longint'(v.s) * longint'(v.n);
            ee = signed_prod(v.e, base);
            pp = signed_prod(v.p, base);
            ll = signed_prod(v.l, base);
            set_taps(v.e, v.p, v.l);
            step(1'b0, 4'sd0, v.e, 1'b0, 1'b1); // flush idle period
            for (int k = 0; k < int'(v.n); k++) step(1'b1, v.s, v.e, 1'b0, 1'b0);
            step(1'b0, 4'sd0, v.e, 1'b0, 1'b1);
            check("R5 valid after dump", longint'(out_valid), 1);
            check("R2/R3 early sum", longint'(out_early), ee);
            check("R2/R3 prompt sum", longint'(out_prompt), pp);
            check("R2/R3 late sum", longint'(out_late), ll);
            check("R4 count", longint'(out_count), longint'(v.n));
            check("R7 disc", longint'(out_disc), ee - ll);
            step(1'b0, 4'sd0, v.e, 1'b0, 1'b0);
            check("R5 valid drops", longint'(out_valid), 0);
            check("R8 early holds", longint'(out_early), ee);
        end

        // invalid samples carry data but must not count
        set_taps(1'b0, 1'b1, 1'b0);
        step(1'b0, 4'sd0, 1'b0, 1'b0, 1'b1);
        for (int k = 0; k < 3; k++) begin
            step(1'b1, 4'sd2, 1'b0, 1'b0, 1'b0);
            step(1'b0, 4'sd7, 1'b0, 1'b0, 1'b0);
            step(1'b0, -4'sd8, 1'b0, 1'b0, 1'b0);
        end
        step(1'b0, 4'sd0, 1'b0, 1'b0, 1'b1);
        check("R4 ignored count", longint'(out_count), 3);
        check("R4 ignored early", longint'(out_early), 6);
        check("R4 ignored prompt", longint'(out_prompt), -6);

        // sample with dump, then back-to-back dump
        set_taps(1'b1, 1'b0, 1'b1);
        step(1'b0, 4'sd0, 1'b1, 1'b0, 1'b1);
        for (int k = 0; k < 4; k++) step(1'b1, 4'sd1, 1'b1, 1'b0, 1'b0);
        step(1'b1, 4'sd5, 1'b1, 1'b0, 1'b1);
        check("R6 old count", longint'(out_count), 4);
        check("R6 old early", longint'(out_early), -4);
        check("R6 old prompt", longint'(out_prompt), 4);
        step(1'b0, 4'sd0, 1'b1, 1'b0, 1'b1);
        check("R10 second valid", longint'(out_valid), 1);
        check("R10 second count", longint'(out_count), 1);
        check("R10 second early", longint'(out_early), -5);
        check("R10 second prompt", longint'(out_prompt), 5);
        check("R10 second late", longint'(out_late), -5);
        check("R10 second disc", longint'(out_disc), 0);
        step(1'b0, 4'sd0, 1'b1, 1'b0, 1'b0);
        check("R5 valid after pair", longint'(out_valid), 0);

        // full-length period at the extreme value
        set_taps(1'b0, 1'b1, 1'b1);
        step(1'b0, 4'sd0, 1'b0, 1'b0, 1'b1);
        for (int k = 0; k < 16368; k++) step(1'b1, -4'sd8, 1'b0, 1'b0, 1'b0);
        step(1'b0, 4'sd0, 1'b0, 1'b0, 1'b1);
        check("R9 count", longint'(out_count), 16368);
        check("R9 early", longint'(out_early), -130944);
        check("R9 prompt", longint'(out_prompt), 130944);
        check("R9 late", longint'(out_late), 130944);
        check("R9 disc", longint'(out_disc), -261888);

        step(1'b0, 4'sd0, 1'b0, 1'b0, 1'b0);
        finish_run();
    end

endmodule